// File: doc/BRIEF.md
# Line Sharer Tracker with Invalidation Ack Accounting

This block keeps, for one cached line, the set of private caches that hold a copy and the identity of the cache that owns it exclusively. It works out the signed acknowledgement count that goes into a reply to a requester. It also produces the mask of caches that must be invalidated when that requester asks for write permission.

The block also runs the pending-acknowledgement counter used while the line is being evicted. A load strobe copies the current number of sharers into the counter. Each incoming acknowledgement subtracts the count it carries. The block flags the acknowledgement that brings the counter exactly to zero. If an acknowledgement carries more than remains, the counter stops at zero and a sticky error flag is raised.

The surrounding controller drives the update strobes from its own state machine. It reads the combinational outputs in the same cycle as the request they answer.

Top module: `sharer_tracker`

## Requirements
- R1: After a synchronous active-low reset, the sharer bitmap is all zeros, the owner ID is 0, the error flag is 0 and the acks-done flag is 0.
- R2: `add_en` sets bit `add_id` of the bitmap and `rem_en` clears bit `rem_id`, both at the next clock edge. Bit i of `sharers` stands for cache i. When both strobes name the same ID in one cycle, the bit ends up set.
- R3: `clr_en` empties the bitmap at the next edge. An `add_en` in the same cycle is applied after the clear, so that only its bit remains.
- R4: `own_en` replaces the bitmap with a single bit at `own_id` and loads `owner` with `own_id`. It overrides add, remove and clear in the same cycle.
- R5: `reply_acks` is a two's-complement value of width $clog2(N+1)+1. It equals minus the number of set bits in the bitmap, plus one when bit `req_id` is set.
- R6: `upg_acks` equals one minus the number of set bits in the bitmap, whatever the value of `req_id`.
- R7: `inv_mask` equals the bitmap with bit `req_id` forced to zero.
- R8: `alloc_en` loads the pending counter with the current number of set bits in the bitmap and clears the error flag. An acknowledgement presented in the same cycle is ignored, and `acks_done` stays low in that cycle.
- R9: Without `alloc_en`, `ack_en` subtracts `ack_cnt` from the pending counter at the next edge. `acks_done` is high, in the same cycle as `ack_en`, exactly when `ack_cnt` equals the pending value.
- R10: An acknowledgement whose count exceeds the pending value leaves the counter at zero and sets `pend_err`. `pend_err` stays set until the next `alloc_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| add_en | input | 1 | Add a sharer |
| add_id | input | $clog2(N) | Cache ID to add |
| rem_en | input | 1 | Remove a sharer |
| rem_id | input | $clog2(N) | Cache ID to remove |
| clr_en | input | 1 | Empty the sharer set |
| own_en | input | 1 | Mark an exclusive owner |
| own_id | input | $clog2(N) | Owner cache ID |
| req_id | input | $clog2(N) | Requester ID for the reply outputs |
| alloc_en | input | 1 | Load the pending counter from the sharer count |
| ack_en | input | 1 | Acknowledgement received |
| ack_cnt | input | $clog2(N+1) | Count carried by the acknowledgement |
| sharers | output | N | Sharer bitmap |
| owner | output | $clog2(N) | Exclusive owner ID |
| reply_acks | output | $clog2(N+1)+1 | Signed ack count for a data reply |
| upg_acks | output | $clog2(N+1)+1 | Signed ack count for an upgrade reply |
| inv_mask | output | N | Invalidation destinations for the requester |
| acks_done | output | 1 | This acknowledgement completes the count |
| pend_err | output | 1 | Sticky over-acknowledgement flag |

## Verification
The hardest state to reach is a saturated counter with the error flag set. From there, a following zero-count acknowledgement must still report completion. The stimulus builds a three-member sharer set, loads the counter from it, and then sends one acknowledgement carrying five. It follows with a zero-count acknowledgement and a fresh load, which show that the counter sat at zero and that only the load clears the flag. A load that coincides with an acknowledgement is also driven, to show that the acknowledgement is dropped.

// File: rtl/sharer_pkg.sv
// Package: shared limits and helpers for the sharer tracker.
// Assumes no more than PEER_LIMIT private caches per line.
package sharer_pkg;
    localparam int PEER_LIMIT = 64;

    // Count set bits of a peer bitmap padded to PEER_LIMIT.
    function automatic int unsigned count_bits(input logic [PEER_LIMIT-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < PEER_LIMIT; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/sharer_set.sv
// Module: sharer_set
// Holds the sharer bitmap and the exclusive owner ID.
// Update priority: owner marking > (clear, then remove, then add).
module sharer_set #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           add_en,
    input  logic [IDW-1:0] add_id,
    input  logic           rem_en,
    input  logic [IDW-1:0] rem_id,
    input  logic           clr_en,
    input  logic           own_en,
    input  logic [IDW-1:0] own_id,
    output logic [N-1:0]   sharers,
    output logic [IDW-1:0] owner
);
    logic [N-1:0] nxt;

    // Next bitmap from the update strobes in priority order.
    always_comb begin
        nxt = sharers;
        if (clr_en) nxt = '0;
        if (rem_en) nxt[rem_id] = 1'b0;
        if (add_en) nxt[add_id] = 1'b1;
        if (own_en) begin
            nxt = '0;
            nxt[own_id] = 1'b1;
        end
    end

    // Register the bitmap and the owner ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sharers <= '0;
            owner   <= '0;
        end else begin
            sharers <= nxt;
            if (own_en) owner <= own_id;
        end
    end
endmodule

// File: rtl/ack_calc.sv
// Module: ack_calc
// Combinational: sharer population, signed reply ack counts and the
// invalidation mask for the current requester.
module ack_calc #(
    parameter int N    = 8,
    parameter int IDW  = $clog2(N),
    parameter int CNTW = $clog2(N + 1),
    localparam int ACKW = CNTW + 1
) (
    input  logic [N-1:0]   sharers,
    input  logic [IDW-1:0] req_id,
    output logic [CNTW-1:0] pop,
    output logic [ACKW-1:0] reply_acks,
    output logic [ACKW-1:0] upg_acks,
    output logic [N-1:0]   inv_mask
);
    import sharer_pkg::*;

    logic [PEER_LIMIT-1:0] padded;
    logic                  req_is_sh;

    // Population count of the sharer set.
    always_comb begin
        padded         = '0;
        padded[N-1:0]  = sharers;
        pop            = CNTW'(count_bits(padded));
    end

    // Reply counts: negative population, requester excluded where it applies.
    always_comb begin
        req_is_sh  = sharers[req_id];
        reply_acks = ACKW'(0) - ACKW'(pop) + ACKW'(req_is_sh);
        upg_acks   = ACKW'(1) - ACKW'(pop);
        inv_mask   = sharers;
        inv_mask[req_id] = 1'b0;
    end
endmodule

// File: rtl/pend_counter.sv
// Module: pend_counter
// Pending acknowledgement counter for an eviction. Loads from the sharer
// count, subtracts carried counts, saturates at zero with a sticky error.
module pend_counter #(
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_en,
    input  logic [CNTW-1:0] pop,
    input  logic            ack_en,
    input  logic [CNTW-1:0] ack_cnt,
    output logic            acks_done,
    output logic            pend_err
);
    logic [CNTW-1:0] pend;
    logic            take_ack;

    // An ack counts only when no load is in progress.
    always_comb begin
        take_ack  = ack_en && !alloc_en;
        acks_done = take_ack && (ack_cnt == pend);
    end

    // Load, subtract with saturation, and keep the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            pend_err <= 1'b0;
        end else if (alloc_en) begin
            pend     <= pop;
            pend_err <= 1'b0;
        end else if (take_ack) begin
            if (ack_cnt > pend) begin
                pend     <= '0;
                pend_err <= 1'b1;
            end else begin
                pend <= pend - ack_cnt;
            end
        end
    end
endmodule

// File: rtl/sharer_tracker.sv
// Module: sharer_tracker (top)
// Sharer bitmap, owner, reply ack counts, invalidation mask and the
// eviction ack counter for one line. Inputs are single-cycle strobes.
module sharer_tracker #(
    parameter int N    = 8,
    localparam int IDW  = $clog2(N),
    localparam int CNTW = $clog2(N + 1),
    localparam int ACKW = CNTW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic [IDW-1:0]  add_id,
    input  logic            rem_en,
    input  logic [IDW-1:0]  rem_id,
    input  logic            clr_en,
    input  logic            own_en,
    input  logic [IDW-1:0]  own_id,
    input  logic [IDW-1:0]  req_id,
    input  logic            alloc_en,
    input  logic            ack_en,
    input  logic [CNTW-1:0] ack_cnt,
    output logic [N-1:0]    sharers,
    output logic [IDW-1:0]  owner,
    output logic [ACKW-1:0] reply_acks,
    output logic [ACKW-1:0] upg_acks,
    output logic [N-1:0]    inv_mask,
    output logic            acks_done,
    output logic            pend_err
);
    logic [CNTW-1:0] pop;

    sharer_set #(.N(N), .IDW(IDW)) u_set (
        .clk(clk), .rst_n(rst_n),
        .add_en(add_en), .add_id(add_id),
        .rem_en(rem_en), .rem_id(rem_id),
        .clr_en(clr_en),
        .own_en(own_en), .own_id(own_id),
        .sharers(sharers), .owner(owner)
    );

    ack_calc #(.N(N), .IDW(IDW), .CNTW(CNTW)) u_calc (
        .sharers(sharers), .req_id(req_id), .pop(pop),
        .reply_acks(reply_acks), .upg_acks(upg_acks), .inv_mask(inv_mask)
    );

    pend_counter #(.CNTW(CNTW)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .pop(pop),
        .ack_en(ack_en), .ack_cnt(ack_cnt),
        .acks_done(acks_done), .pend_err(pend_err)
    );
endmodule

// File: rtl/sharer_tracker_chk.sv
// Module: sharer_tracker_chk
// Temporal checks on the tracker's ports, attached by bind.
module sharer_tracker_chk #(
    parameter int N    = 8,
    localparam int IDW  = $clog2(N),
    localparam int CNTW = $clog2(N + 1),
    localparam int ACKW = CNTW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            add_en,
    input logic [IDW-1:0]  add_id,
    input logic            rem_en,
    input logic            clr_en,
    input logic            own_en,
    input logic [IDW-1:0]  own_id,
    input logic [IDW-1:0]  req_id,
    input logic            alloc_en,
    input logic            ack_en,
    input logic [N-1:0]    sharers,
    input logic [IDW-1:0]  owner,
    input logic [ACKW-1:0] reply_acks,
    input logic [ACKW-1:0] upg_acks,
    input logic [N-1:0]    inv_mask,
    input logic            acks_done,
    input logic            pend_err
);
    a_r2_add_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !own_en) |=> sharers[$past(add_id)]);

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !add_en && !own_en) |=> (sharers == '0));

    a_r4_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
        own_en |=> ($countones(sharers) == 1 && sharers[$past(own_id)]
                    && owner == $past(own_id)));

    a_r5_sharer_reply_matches_upg: assert property (@(posedge clk) disable iff (!rst_n)
        sharers[req_id] |-> (reply_acks == upg_acks));

    a_r7_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_mask & ~sharers) == '0) && !inv_mask[req_id]);

    a_r8_alloc_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !acks_done);

    a_r9_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        acks_done |-> ack_en);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_err && !alloc_en) |=> pend_err);

    a_r8_alloc_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> !pend_err);
endmodule

bind sharer_tracker sharer_tracker_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .add_en(add_en), .add_id(add_id), .rem_en(rem_en),
    .clr_en(clr_en), .own_en(own_en), .own_id(own_id),
    .req_id(req_id), .alloc_en(alloc_en), .ack_en(ack_en),
    .sharers(sharers), .owner(owner),
    .reply_acks(reply_acks), .upg_acks(upg_acks), .inv_mask(inv_mask),
    .acks_done(acks_done), .pend_err(pend_err)
);

// File: tb/sim_sharer_tracker.sv
`timescale 1ns/1ps
// Directed bench for sharer_tracker, one task per scenario.
module sim_sharer_tracker;
    localparam int N    = 8;
    localparam int IDW  = $clog2(N);
    localparam int CNTW = $clog2(N + 1);
    localparam int ACKW = CNTW + 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            add_en, rem_en, clr_en, own_en, alloc_en, ack_en;
    logic [IDW-1:0]  add_id, rem_id, own_id, req_id;
    logic [CNTW-1:0] ack_cnt;
    logic [N-1:0]    sharers, inv_mask;
    logic [IDW-1:0]  owner;
    logic [ACKW-1:0] reply_acks, upg_acks;
    logic            acks_done, pend_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sharer_tracker #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .add_en(add_en), .add_id(add_id), .rem_en(rem_en), .rem_id(rem_id),
        .clr_en(clr_en), .own_en(own_en), .own_id(own_id), .req_id(req_id),
        .alloc_en(alloc_en), .ack_en(ack_en), .ack_cnt(ack_cnt),
        .sharers(sharers), .owner(owner), .reply_acks(reply_acks),
        .upg_acks(upg_acks), .inv_mask(inv_mask),
        .acks_done(acks_done), .pend_err(pend_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        add_en = 0; rem_en = 0; clr_en = 0; own_en = 0;
        alloc_en = 0; ack_en = 0; ack_cnt = '0;
    endtask

    // Apply strobes set by the caller for one edge, then clear them.
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic add(input int id);
        @(negedge clk); add_en = 1; add_id = IDW'(id); tick();
    endtask

    task automatic t_reset();
        check("R1 sharers", int'(sharers), 0);
        check("R1 owner", int'(owner), 0);
        check("R1 err", int'(pend_err), 0);
        check("R1 done", int'(acks_done), 0);
    endtask

    task automatic t_add_remove();
        add(1); add(3); add(6);
        check("R2 adds", int'(sharers), 'b0100_1010);
        @(negedge clk); rem_en = 1; rem_id = 3; tick();
        check("R2 remove", int'(sharers), 'b0100_0010);
        @(negedge clk); rem_en = 1; rem_id = 5; add_en = 1; add_id = 5; tick();
        check("R2 same id add wins", int'(sharers), 'b0110_0010);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_en = 1; add_en = 1; add_id = 2; tick();
        check("R3 clear then add", int'(sharers), 'b0000_0100);
        @(negedge clk); clr_en = 1; tick();
        check("R3 clear", int'(sharers), 0);
    endtask

    task automatic t_owner();
        add(0); add(7);
        @(negedge clk); own_en = 1; own_id = 4; add_en = 1; add_id = 2;
        clr_en = 1; tick();
        check("R4 single sharer", int'(sharers), 'b0001_0000);
        check("R4 owner id", int'(owner), 4);
    endtask

    task automatic t_reply();
        add(0); add(2);   // set is {0,2,4}
        @(negedge clk); req_id = 2; #1;
        check("R5 sharer requester", int'($signed(reply_acks)), -2);
        check("R6 upgrade", int'($signed(upg_acks)), -2);
        check("R7 mask minus req", int'(inv_mask), 'b0001_0001);
        req_id = 5; #1;
        check("R5 outsider requester", int'($signed(reply_acks)), -3);
        check("R6 upgrade outsider", int'($signed(upg_acks)), -2);
        check("R7 mask outsider", int'(inv_mask), 'b0001_0101);
        @(negedge clk); clr_en = 1; tick();
        req_id = 0; #1;
        check("R5 empty set", int'($signed(reply_acks)), 0);
        check("R6 empty set", int'($signed(upg_acks)), 1);
        check("R7 empty mask", int'(inv_mask), 0);
    endtask

    task automatic t_pending();
        add(1); add(3); add(5);   // three sharers
        @(negedge clk); alloc_en = 1; tick();
        @(negedge clk); ack_en = 1; ack_cnt = 1; #1;
        check("R9 partial ack", int'(acks_done), 0);
        tick();
        @(negedge clk); ack_en = 1; ack_cnt = 2; #1;
        check("R9 final ack", int'(acks_done), 1);
        tick();
        @(negedge clk); alloc_en = 1; ack_en = 1; ack_cnt = 3; #1;
        check("R8 ack during load", int'(acks_done), 0);
        tick();
        @(negedge clk); ack_en = 1; ack_cnt = 3; #1;
        check("R8 load kept full count", int'(acks_done), 1);
        tick();
    endtask

    task automatic t_underflow();
        @(negedge clk); alloc_en = 1; tick();
        @(negedge clk); ack_en = 1; ack_cnt = 5; #1;
        check("R10 over ack not done", int'(acks_done), 0);
        tick();
        check("R10 err set", int'(pend_err), 1);
        @(negedge clk); ack_en = 1; ack_cnt = 0; #1;
        check("R10 saturated at zero", int'(acks_done), 1);
        tick();
        @(negedge clk); tick();
        check("R10 err sticky", int'(pend_err), 1);
        @(negedge clk); alloc_en = 1; tick();
        check("R8 load clears err", int'(pend_err), 0);
    endtask

    initial begin
        idle();
        add_id = '0; rem_id = '0; own_id = '0; req_id = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_add_remove();
        t_clear();
        t_owner();
        t_reply();
        t_pending();
        t_underflow();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule